// File: doc/BRIEF.md
# Printer Stream DMA Controller

This block moves bytes from memory to a raster printer's parallel port. Software programs it through a small register slave: a control word holding a go bit, a two-bit transfer mode and two printer option bits; a start address given as a word index (byte address divided by 8); and a length counter. A read master fetches 8-byte words from memory one at a time. The engine then hands the bytes to the printer one by one over a data/strobe handshake, paced by the printer's ready line.

Two transfer modes are built. One-shot mode sends a single byte: lane 0 of the word at the start index. Stream mode sends a block whose length software has encoded as (bytes - 64)/16. The engine counts 16-byte blocks down to zero and then sends a fixed tail of 64 bytes. The printer and display mode codes are decoded, but they move no data.

Printer commands are triggered by bus reads of dedicated offsets. Each such read produces a one-cycle pulse on its own command line. A status word reports whether the printer is online, whether it is ready, and whether the transfer has ended. Software polls the end bit and then clears the go bit.

Top module: `prn_dma_top`

## Requirements
- R1: After reset, `prn_strobe`, `mem_req`, `prn_cmd`, `prn_print_sel`, `prn_spp` and `bus_rdata` are all zero.
- R2: A write to offset 0 sets the control word: bit0 go, bits 2:1 mode, bit3 print select, bit4 option enable. The same word reads back from offset 0, and bits 3 and 4 drive `prn_print_sel` and `prn_spp`. Offsets 1 and 2 hold the low 16 and high bits of the start word index. Offset 4 reads status: bit0 online, bit1 ready, bit2 transfer ended. Read data appears on the cycle after `bus_rd`.
- R3: The length counter at offset 3 is loaded by two successive writes of `bus_wdata[7:0]`, the low byte first. It reads back as 16 bits.
- R4: A read of offset 8+k (k = 0 clear, 1 reset, 2 line terminate, 3 form feed, 4 end of transmission) raises `prn_cmd[k]` alone, for exactly one cycle.
- R5: With mode 2'b10 and the go bit set, the engine fetches the word at the start index and sends exactly one byte, namely bits 7:0 of that word. It then reports the end of the transfer.
- R6: With mode 2'b11 and length N, the engine sends 16*N+64 bytes from consecutive byte addresses, starting at start index * 8. Byte lane i of each word is `mem_data[8i+7:8i]`. The engine then reports the end of the transfer.
- R7: `prn_strobe` is high for one cycle at a time. `prn_data` stays stable for the cycle after the strobe. A strobe is only issued when `prn_ready` was high at the clock edge before it, and at least one guard cycle separates two strobes.
- R8: The ended status stays set until software clears the go bit. It then drops, and a new transfer can be started.
- R9: If `prn_online` is low during a transfer, or when the go bit is set, the engine stops issuing strobes and memory requests and reports the end of the transfer.
- R10: Modes 2'b00 and 2'b01 report the end of the transfer without any memory request or strobe.
- R11: `mem_req` stays high until `mem_ack` is seen, unless the transfer is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | WADDR_W | Word index being fetched |
| mem_ack | input | 1 | Fetch completes; `mem_data` valid |
| mem_data | input | 8*WORD_BYTES | Fetched word, lane 0 in the low byte |
| prn_data | output | 8 | Byte to the printer |
| prn_strobe | output | 1 | One-cycle strobe marking a byte |
| prn_ready | input | 1 | Printer accepts a byte |
| prn_online | input | 1 | Printer is online |
| prn_cmd | output | 5 | One-cycle command pulses |
| prn_print_sel | output | 1 | Print (1) versus plot (0) selection |
| prn_spp | output | 1 | Option enable line |

## Verification
A vector table drives one-shot transfers at low and high word indices. It also drives stream transfers of 96, 112 and 144 bytes, including one that ends near the top of the address space. Comparing every captured byte with a memory pattern derived from the byte address separates lane-ordering errors, address-increment errors and block/tail count errors. The high index checks that both address halves are written correctly. Directed tests then cover each mode in turn: the non-transfer modes, which must move nothing, and an offline drop in mid-stream and at start, which must freeze the byte count. A printer model that lowers ready for several cycles after each strobe exposes any engine that fails to wait for it.

// File: rtl/prn_dma_pkg.sv
package prn_dma_pkg;
  localparam int BUS_AW  = 4;
  localparam int BUS_DW  = 16;
  localparam int LEN_W   = 16;
  localparam int NUM_CMD = 5;

  localparam logic [BUS_AW-1:0] OFF_CTRL    = 4'd0;
  localparam logic [BUS_AW-1:0] OFF_ADDR_LO = 4'd1;
  localparam logic [BUS_AW-1:0] OFF_ADDR_HI = 4'd2;
  localparam logic [BUS_AW-1:0] OFF_LEN     = 4'd3;
  localparam logic [BUS_AW-1:0] OFF_STAT    = 4'd4;
  localparam int                OFF_CMD0    = 8;

  typedef enum logic [1:0] {
    MODE_PRINTER = 2'b00,
    MODE_DISPLAY = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_STREAM  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEND, ST_STRB, ST_GAP, ST_DONE
  } eng_state_e;
endpackage

// File: rtl/prn_dma_regs.sv
module prn_dma_regs
  import prn_dma_pkg::*;
#(
  parameter int WADDR_W = 29
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic [BUS_DW-1:0]        bus_wdata,
  output logic [BUS_DW-1:0]        bus_rdata,
  input  logic                     stat_online,
  input  logic                     stat_ready,
  input  logic                     stat_end,
  output logic                     ctl_go,
  output logic [1:0]               ctl_mode,
  output logic                     ctl_print,
  output logic                     ctl_spp,
  output logic [WADDR_W-1:0]       start_widx,
  output logic [LEN_W-1:0]         len_cnt,
  output logic [NUM_CMD-1:0]       cmd_pulse
);
  localparam int HI_W = WADDR_W - 16;

  logic len_hi_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_go      <= 1'b0;
      ctl_mode    <= 2'b00;
      ctl_print   <= 1'b0;
      ctl_spp     <= 1'b0;
      start_widx  <= '0;
      len_cnt     <= '0;
      len_hi_next <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_CTRL: begin
          ctl_go    <= bus_wdata[0];
          ctl_mode  <= bus_wdata[2:1];
          ctl_print <= bus_wdata[3];
          ctl_spp   <= bus_wdata[4];
        end
        OFF_ADDR_LO: start_widx[15:0] <= bus_wdata;
        OFF_ADDR_HI: start_widx[WADDR_W-1:16] <= bus_wdata[HI_W-1:0];
        OFF_LEN: begin
          if (len_hi_next) len_cnt[15:8] <= bus_wdata[7:0];
          else             len_cnt[7:0]  <= bus_wdata[7:0];
          len_hi_next <= ~len_hi_next;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_CTRL:    bus_rdata <= {11'd0, ctl_spp, ctl_print, ctl_mode, ctl_go};
        OFF_ADDR_LO: bus_rdata <= start_widx[15:0];
        OFF_ADDR_HI: bus_rdata <= BUS_DW'(start_widx[WADDR_W-1:16]);
        OFF_LEN:     bus_rdata <= len_cnt;
        OFF_STAT:    bus_rdata <= {13'd0, stat_end, stat_ready, stat_online};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
    localparam logic [BUS_AW-1:0] CMD_OFF = BUS_AW'(OFF_CMD0 + k);
    always_ff @(posedge clk) begin
      if (rst) cmd_pulse[k] <= 1'b0;
      else     cmd_pulse[k] <= bus_rd && (bus_addr == CMD_OFF);
    end
  end

  // R4: at most one command line at a time
  assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse));
  // R4: a pulse lasts one cycle unless the bus keeps reading
  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ((|cmd_pulse) && !bus_rd) |=> (cmd_pulse == '0));
endmodule

// File: rtl/prn_dma_engine.sv
module prn_dma_engine
  import prn_dma_pkg::*;
#(
  parameter int WADDR_W    = 29,
  parameter int WORD_BYTES = 8,
  parameter int BLK_BYTES  = 16,
  parameter int TAIL_BLKS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [1:0]                mode,
  input  logic [WADDR_W-1:0]        start_widx,
  input  logic [LEN_W-1:0]          len_cnt,
  input  logic                      online,
  input  logic                      ready,
  output logic                      mem_req,
  output logic [WADDR_W-1:0]        mem_addr,
  input  logic                      mem_ack,
  input  logic [8*WORD_BYTES-1:0]   mem_data,
  output logic [7:0]                prn_data,
  output logic                      prn_strobe,
  output logic                      xfer_end
);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int BIB_W  = $clog2(BLK_BYTES);
  localparam int TAIL_W = $clog2(TAIL_BLKS);
  localparam logic [LANE_W-1:0] LANE_MAX = LANE_W'(WORD_BYTES - 1);
  localparam logic [BIB_W-1:0]  BIB_MAX  = BIB_W'(BLK_BYTES - 1);
  localparam logic [TAIL_W-1:0] TAIL_MAX = TAIL_W'(TAIL_BLKS - 1);

  eng_state_e state, state_d;
  logic [8*WORD_BYTES-1:0] word_q;
  logic [LANE_W-1:0]       lane;
  logic [BIB_W-1:0]        bib;
  logic [LEN_W-1:0]        blk_left;
  logic [TAIL_W-1:0]       tail;
  logic                    oneshot_q;
  logic                    busy, last_blk_byte, final_byte, mode_moves;

  assign busy          = (state == ST_FETCH) || (state == ST_SEND) ||
                         (state == ST_STRB)  || (state == ST_GAP);
  assign last_blk_byte = (bib == BIB_MAX);
  assign final_byte    = last_blk_byte && (blk_left == '0) && (tail == TAIL_MAX);
  assign mode_moves    = (xfer_mode_e'(mode) == MODE_ONESHOT) ||
                         (xfer_mode_e'(mode) == MODE_STREAM);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (go) state_d = (mode_moves && online) ? ST_FETCH : ST_DONE;
      ST_FETCH: if (mem_ack) state_d = ST_SEND;
      ST_SEND:  if (ready) state_d = ST_STRB;
      ST_STRB:  state_d = ST_GAP;
      ST_GAP: begin
        if (oneshot_q || final_byte) state_d = ST_DONE;
        else if (lane == LANE_MAX)   state_d = ST_FETCH;
        else                         state_d = ST_SEND;
      end
      ST_DONE:  if (!go) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (busy) begin
      if (!go)          state_d = ST_IDLE;
      else if (!online) state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      prn_strobe <= 1'b0;
      xfer_end   <= 1'b0;
      prn_data   <= '0;
      word_q     <= '0;
      mem_addr   <= '0;
      lane       <= '0;
      bib        <= '0;
      blk_left   <= '0;
      tail       <= '0;
      oneshot_q  <= 1'b0;
    end else begin
      state      <= state_d;
      mem_req    <= (state_d == ST_FETCH);
      prn_strobe <= (state_d == ST_STRB);
      xfer_end   <= (state_d == ST_DONE);
      if (state == ST_IDLE && state_d == ST_FETCH) begin
        mem_addr  <= start_widx;
        blk_left  <= len_cnt;
        tail      <= '0;
        lane      <= '0;
        bib       <= '0;
        oneshot_q <= (xfer_mode_e'(mode) == MODE_ONESHOT);
      end
      if (state == ST_FETCH && state_d == ST_SEND) word_q <= mem_data;
      if (state == ST_SEND && state_d == ST_STRB) prn_data <= word_q[{lane, 3'b000} +: 8];
      if (state == ST_GAP && (state_d == ST_SEND || state_d == ST_FETCH)) begin
        lane <= lane + 1'b1;
        bib  <= bib + 1'b1;
        if (last_blk_byte) begin
          if (blk_left != '0) blk_left <= blk_left - 1'b1;
          else                tail     <= tail + 1'b1;
        end
        if (lane == LANE_MAX) mem_addr <= mem_addr + 1'b1;
      end
    end
  end

  // R7: single-cycle strobe, data held, strobe only after ready
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    prn_strobe |=> !prn_strobe);
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    prn_strobe |=> $stable(prn_data));
  assert_strobe_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(prn_strobe) |-> $past(ready));
  // R11: request held until acknowledged
  assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && online && go) |=> mem_req);
  // R9: offline during a transfer ends it
  assert_offline_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !online) |=> (state == ST_DONE));
  // R10: nothing moves once the transfer has ended
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> (!mem_req && !prn_strobe));
  // R8: ended status holds while go stays set
  assert_end_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && go) |=> xfer_end);
endmodule

// File: rtl/prn_dma_top.sv
module prn_dma_top
  import prn_dma_pkg::*;
#(
  parameter int WADDR_W    = 29,
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [3:0]              bus_addr,
  input  logic [15:0]             bus_wdata,
  output logic [15:0]             bus_rdata,
  output logic                    mem_req,
  output logic [WADDR_W-1:0]      mem_addr,
  input  logic                    mem_ack,
  input  logic [8*WORD_BYTES-1:0] mem_data,
  output logic [7:0]              prn_data,
  output logic                    prn_strobe,
  input  logic                    prn_ready,
  input  logic                    prn_online,
  output logic [4:0]              prn_cmd,
  output logic                    prn_print_sel,
  output logic                    prn_spp
);
  logic               go, xfer_end;
  logic [1:0]         mode;
  logic [WADDR_W-1:0] start_widx;
  logic [LEN_W-1:0]   len_cnt;

  prn_dma_regs #(.WADDR_W(WADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_online(prn_online), .stat_ready(prn_ready), .stat_end(xfer_end),
    .ctl_go(go), .ctl_mode(mode), .ctl_print(prn_print_sel), .ctl_spp(prn_spp),
    .start_widx(start_widx), .len_cnt(len_cnt), .cmd_pulse(prn_cmd)
  );

  prn_dma_engine #(.WADDR_W(WADDR_W), .WORD_BYTES(WORD_BYTES)) u_engine (
    .clk(clk), .rst(rst), .go(go), .mode(mode), .start_widx(start_widx),
    .len_cnt(len_cnt), .online(prn_online), .ready(prn_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .prn_data(prn_data), .prn_strobe(prn_strobe), .xfer_end(xfer_end)
  );
endmodule

// File: tb/tb_prn_dma_top.sv
module tb_prn_dma_top;
  localparam int WADDR_W = 29;
  localparam int NVEC = 5;
  // {mode[1:0], start word index[31:0], length[15:0]}
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b10, 32'h0000_0100, 16'd0},
    {2'b11, 32'h0000_0200, 16'd2},
    {2'b10, 32'h1ABC_DEF3, 16'd0},
    {2'b11, 32'h0001_2345, 16'd5},
    {2'b11, 32'h1FFF_FFF0, 16'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic mem_req, mem_ack = 0;
  logic [WADDR_W-1:0] mem_addr;
  logic [63:0] mem_data = 0;
  logic [7:0] prn_data;
  logic prn_strobe, prn_ready = 1, prn_online = 1;
  logic [4:0] prn_cmd;
  logic prn_print_sel, prn_spp;

  int checks = 0, errors = 0;
  bit finished = 0;

  prn_dma_top dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] patt(input logic [31:0] a);
    return (a[7:0] + a[15:8]) ^ 8'hA5;
  endfunction

  // memory, printer and protocol monitors
  int lat = 0, acks = 0, strobes = 0, busy = 0, strobe_busy_bad = 0, req_bad = 0;
  int cap_idx = 0;
  logic [7:0] cap [4096];
  logic prev_req = 0, prev_ack = 0;
  bit abort_ok = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0; lat <= 0; prn_ready <= 1; busy <= 0;
    end else begin
      if (mem_ack) mem_ack <= 0;
      else if (mem_req) begin
        if (lat == 2) begin
          mem_ack <= 1; lat <= 0; acks <= acks + 1;
          for (int i = 0; i < 8; i++) mem_data[8*i +: 8] <= patt({3'b000, mem_addr} * 8 + i);
        end else lat <= lat + 1;
      end else lat <= 0;
      if (prn_strobe) begin
        if (busy != 0) strobe_busy_bad <= strobe_busy_bad + 1;
        cap[cap_idx % 4096] <= prn_data;
        cap_idx <= cap_idx + 1;
        strobes <= strobes + 1;
        busy <= 3; prn_ready <= 0;
      end else if (busy > 1) busy <= busy - 1;
      else if (busy == 1) begin busy <= 0; prn_ready <= 1; end
      if (prev_req && !prev_ack && !mem_req && !abort_ok) req_bad <= req_bad + 1;
      prev_req <= mem_req; prev_ack <= mem_ack;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_end(output bit ok);
    logic [15:0] s;
    ok = 0;
    for (int n = 0; n < 3000 && !ok; n++) begin
      bus_read(4'd4, s);
      ok = s[2];
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit ok;
    int base, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!prn_strobe && !mem_req && prn_cmd == 0 && !prn_print_sel && !prn_spp && bus_rdata == 0,
        "R1", "reset outputs", {prn_strobe, mem_req, prn_cmd, prn_print_sel, prn_spp}, 0);

    // R2 control readback and option pins, status layout
    bus_write(4'd0, 16'h0018);
    bus_read(4'd0, d);
    chk(d == 16'h0018, "R2", "ctrl readback", d, 16'h0018);
    chk(prn_print_sel && prn_spp, "R2", "option pins", {prn_print_sel, prn_spp}, 2'b11);
    bus_read(4'd4, d);
    chk(d == 16'h0003, "R2", "status idle", d, 16'h0003);
    bus_write(4'd2, 16'h0ABC);
    bus_read(4'd2, d);
    chk(d == 16'h0ABC, "R2", "addr hi readback", d, 16'h0ABC);

    // R3 length, low byte first
    bus_write(4'd3, 16'h0034);
    bus_write(4'd3, 16'h0012);
    bus_read(4'd3, d);
    chk(d == 16'h1234, "R3", "length byte order", d, 16'h1234);

    // R4 command pulses
    for (int k = 0; k < 5; k++) begin
      bus_read(4'(8 + k), d);
      chk(prn_cmd == 5'(1 << k), "R4", "command pulse", prn_cmd, 5'(1 << k));
      @(negedge clk);
      chk(prn_cmd == 0, "R4", "command pulse width", prn_cmd, 0);
    end
    bus_write(4'd0, 16'h0000);

    // R5 / R6 / R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m;
      logic [31:0] sw;
      logic [15:0] ln;
      int exp_n, bad_j;
      {m, sw, ln} = VEC[v];
      exp_n = (m == 2'b10) ? 1 : 16 * int'(ln) + 64;
      bus_write(4'd1, sw[15:0]);
      bus_write(4'd2, sw[31:16]);
      bus_write(4'd3, {8'd0, ln[7:0]});
      bus_write(4'd3, {8'd0, ln[15:8]});
      base = cap_idx;
      bus_write(4'd0, {13'd0, m, 1'b1});
      wait_end(ok);
      chk(ok, (m == 2'b10) ? "R5" : "R6", "transfer ended", ok, 1);
      chk(cap_idx - base == exp_n, (m == 2'b10) ? "R5" : "R6", "byte count", cap_idx - base, exp_n);
      bad_j = -1;
      for (int j = 0; j < exp_n; j++)
        if (bad_j < 0 && cap[(base + j) % 4096] != patt(sw * 8 + j)) bad_j = j;
      chk(bad_j < 0, (m == 2'b10) ? "R5" : "R6", "byte contents",
          (bad_j < 0) ? 0 : cap[(base + bad_j) % 4096], (bad_j < 0) ? 0 : patt(sw * 8 + bad_j));
      repeat (10) @(negedge clk);
      bus_read(4'd4, d);
      chk(d[2], "R8", "end held", d[2], 1);
      bus_write(4'd0, 16'h0000);
      bus_read(4'd4, d);
      chk(!d[2], "R8", "end cleared", d[2], 0);
    end
    chk(strobe_busy_bad == 0, "R7", "strobe while printer busy", strobe_busy_bad, 0);
    chk(req_bad == 0, "R11", "request dropped without ack", req_bad, 0);

    // R10 non-transfer modes
    for (int m = 0; m < 2; m++) begin
      int a0, s0;
      a0 = acks; s0 = strobes;
      bus_write(4'd0, {13'd0, 2'(m), 1'b1});
      wait_end(ok);
      chk(ok, "R10", "ended", ok, 1);
      chk(acks == a0 && strobes == s0, "R10", "no traffic", acks - a0 + strobes - s0, 0);
      bus_write(4'd0, 16'h0000);
    end

    // R9 offline mid-stream
    bus_write(4'd1, 16'h0400);
    bus_write(4'd2, 16'h0000);
    bus_write(4'd3, 16'h0005);
    bus_write(4'd3, 16'h0000);
    base = cap_idx;
    bus_write(4'd0, 16'h0007);
    for (int t = 0; t < 2000 && cap_idx - base < 20; t++) @(negedge clk);
    abort_ok = 1;
    prn_online = 0;
    wait_end(ok);
    chk(ok, "R9", "abort ends transfer", ok, 1);
    n = cap_idx;
    repeat (40) @(negedge clk);
    chk(cap_idx == n, "R9", "no strobes after abort", cap_idx - n, 0);
    chk(n - base < 144, "R9", "transfer cut short", n - base, 20);
    bus_write(4'd0, 16'h0000);
    n = acks;
    bus_write(4'd0, 16'h0007);
    wait_end(ok);
    chk(ok && cap_idx == base + (cap_idx - base) && acks == n, "R9", "start while offline",
        acks - n, 0);
    bus_write(4'd0, 16'h0000);
    prn_online = 1;
    repeat (5) @(negedge clk);
    abort_ok = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule